// File: doc/BRIEF.md
# Ethernet Receive Destination Address Filter

This block sits beside a receive MAC and decides, frame by frame, whether a frame is kept. It watches the byte stream the MAC delivers. It stores the first six bytes as the destination address and, in parallel, computes a CRC over those bytes to form a hash index. From these it reaches an accept or reject verdict. The verdict comes from a fixed priority of rules:

- broadcast control
- promiscuous mode
- group hash lookup
- exact station match
- individual hash lookup

When the frame ends, the block issues one completion pulse. With that pulse comes a discard request, which the receive FIFO uses to flush the frame internally. A frame is flushed when it was rejected by address or when it is too short to be a valid frame (a collision fragment).

Configuration inputs are captured on the first byte of each frame. Software may therefore update them at any time without disturbing the frame in progress. Bytes arrive with a valid qualifier, so idle gaps inside a frame are allowed.

Top module: `eth_rx_addr_filter`

## Requirements
- R1: After reset, `addr_done`, `addr_accept`, `frame_done` and `frame_discard` are all 0.
- R2: A destination of all 48 ones is accepted exactly when `cfg_bcast_reject` is 0. This rule overrides promiscuous mode and both hash tables.
- R3: A destination with bit 0 of its first byte equal to 0 is accepted when it equals `cfg_station_addr`. The first received byte is compared with `cfg_station_addr[7:0]`, the second with bits [15:8], and so on.
- R4: A destination with bit 0 of its first byte equal to 0 that fails the exact match is accepted when `cfg_uni_hash[idx]` is 1. The index `idx` is derived as follows:
  - Start a 32-bit register at all ones.
  - For each of the six address bytes, LSB first, shift it left one place.
  - When the bit shifted out XOR the data bit is 1, XOR the register with 0x04C11DB7.
  - `idx` is bits [31:26] of the result.
- R5: A destination with bit 0 of its first byte equal to 1 that is not broadcast is accepted exactly when `cfg_grp_hash[idx]` is 1. The station address plays no part for such a destination.
- R6: With `cfg_promisc` at 1, every non-broadcast destination is accepted.
- R7: `addr_done` pulses for one cycle in the cycle after the clock edge that takes the sixth byte of the frame. `addr_accept` carries the verdict in that cycle and is 0 in every other cycle.
- R8: `frame_done` pulses for one cycle in the cycle after the edge that takes the byte marked `rx_eof`. `frame_discard` is 1 in that cycle when the address verdict was reject.
- R9: A frame of fewer than 64 bytes (counted from the first address byte through the last byte) has `frame_discard` forced to 1. A frame shorter than 6 bytes produces no `addr_done`.
- R10: The configuration inputs are captured with the first byte of a frame. Changes made later in the frame do not affect that frame's verdict.
- R11: A byte is taken only when `rx_valid` is 1 and it either carries `rx_sof` or belongs to an open frame. Cycles with `rx_valid` at 0, and bytes arriving between frames without `rx_sof`, change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_valid | input | 1 | Byte qualifier |
| rx_sof | input | 1 | Marks the first byte of a frame |
| rx_eof | input | 1 | Marks the last byte of a frame |
| rx_data | input | 8 | Received byte |
| cfg_station_addr | input | 48 | Exact-match station address, first byte in [7:0] |
| cfg_uni_hash | input | 64 | Individual address hash table |
| cfg_grp_hash | input | 64 | Group address hash table |
| cfg_bcast_reject | input | 1 | 1 rejects broadcast frames |
| cfg_promisc | input | 1 | 1 accepts every non-broadcast frame |
| addr_done | output | 1 | Address verdict strobe |
| addr_accept | output | 1 | Address verdict, valid with `addr_done` |
| frame_done | output | 1 | End-of-frame strobe |
| frame_discard | output | 1 | Flush request, valid with `frame_done` |

## Verification
The hash paths are the hardest to reach from the ports. A random destination hits a given table bit only when the bench has set that bit, and it fails the exact match almost always. The stimulus therefore computes each destination's hash index in the bench and writes tables that set or clear exactly that bit. It also mixes in a station address that doubles as a group address, to show that the group rule wins. Mid-frame configuration changes and frames ending at 5, 6, 63 and 64 bytes are placed directly, with random valid gaps laid over every frame.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

   localparam logic [31:0] RXF_CRC_POLY = 32'h04C11DB7;

   typedef enum logic [1:0] {
      DA_INDIVIDUAL = 2'd0,
      DA_GROUP      = 2'd1,
      DA_BCAST      = 2'd2
   } da_kind_e;

   // One byte of CRC, data bits taken LSB first, MSB-first shift register
   function automatic logic [31:0] crc_step_byte(input logic [31:0] c, input logic [7:0] b);
      logic [31:0] r;
      r = c;
      for (int k = 0; k < 8; k++) begin
         if (r[31] ^ b[k]) r = {r[30:0], 1'b0} ^ RXF_CRC_POLY;
         else              r = {r[30:0], 1'b0};
      end
      return r;
   endfunction

endpackage

// File: rtl/rxf_frame_track.sv
module rxf_frame_track #(
   parameter int DA_BYTES = 6,
   parameter int MIN_LEN  = 64,
   localparam int CNT_W   = $clog2(MIN_LEN + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rx_valid,
   input  logic             rx_sof,
   input  logic             rx_eof,
   output logic             sof_take,
   output logic             da_we,
   output logic [CNT_W-1:0] da_idx,
   output logic             da_last,
   output logic             eof_take,
   output logic             runt
);

   logic             open_q;
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] pos;
   logic [CNT_W-1:0] len_now;
   logic             take;

   assign take     = rx_valid & (rx_sof | open_q);
   assign pos      = rx_sof ? '0 : cnt_q;
   assign len_now  = (pos == CNT_W'(MIN_LEN)) ? pos : pos + 1'b1;
   assign sof_take = take & rx_sof;
   assign da_we    = take & (pos < CNT_W'(DA_BYTES));
   assign da_idx   = pos;
   assign da_last  = take & (pos == CNT_W'(DA_BYTES - 1));
   assign eof_take = take & rx_eof;
   assign runt     = len_now < CNT_W'(MIN_LEN);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         open_q <= 1'b0;
         cnt_q  <= '0;
      end else if (take) begin
         open_q <= ~rx_eof;
         cnt_q  <= len_now;
      end
   end

endmodule

// File: rtl/rxf_da_hash.sv
module rxf_da_hash
   import rxf_pkg::*;
#(
   parameter int DA_BYTES  = 6,
   parameter int HASH_BITS = 6,
   parameter int CNT_W     = 7,
   localparam int DA_W     = 8 * DA_BYTES
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 sof_take,
   input  logic                 da_we,
   input  logic [CNT_W-1:0]     da_idx,
   input  logic [7:0]           rx_data,
   output logic [DA_W-1:0]      da,
   output logic [HASH_BITS-1:0] hash_idx
);

   logic [31:0] crc_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     crc_q <= '1;
      else if (da_we) crc_q <= crc_step_byte(sof_take ? 32'hFFFF_FFFF : crc_q, rx_data);
   end

   assign hash_idx = crc_q[31 -: HASH_BITS];

   for (genvar g = 0; g < DA_BYTES; g++) begin : g_slot
      logic [7:0] b_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                                 b_q <= '0;
         else if (da_we && da_idx == CNT_W'(g))      b_q <= rx_data;
      end
      assign da[8*g +: 8] = b_q;
   end

endmodule

// File: rtl/rxf_match.sv
module rxf_match
   import rxf_pkg::*;
#(
   parameter int DA_BYTES           = 6,
   parameter int HASH_BITS          = 6,
   parameter bit BCAST_OVER_PROMISC = 1'b1,
   localparam int DA_W              = 8 * DA_BYTES,
   localparam int HASH_W            = 1 << HASH_BITS
) (
   input  logic [DA_W-1:0]      da,
   input  logic [HASH_BITS-1:0] hash_idx,
   input  logic [DA_W-1:0]      station,
   input  logic [HASH_W-1:0]    uni_hash,
   input  logic [HASH_W-1:0]    grp_hash,
   input  logic                 bcast_reject,
   input  logic                 promisc,
   output logic                 accept
);

   da_kind_e kind;
   logic     addr_hit;

   assign kind = (&da) ? DA_BCAST : (da[0] ? DA_GROUP : DA_INDIVIDUAL);

   always_comb begin
      case (kind)
         DA_BCAST: addr_hit = ~bcast_reject;
         DA_GROUP: addr_hit = grp_hash[hash_idx];
         default:  addr_hit = (da == station) | uni_hash[hash_idx];
      endcase
   end

   if (BCAST_OVER_PROMISC) begin : g_bcast_first
      assign accept = (kind == DA_BCAST) ? addr_hit : (promisc | addr_hit);
   end else begin : g_promisc_first
      assign accept = promisc | addr_hit;
   end

endmodule

// File: rtl/eth_rx_addr_filter.sv
module eth_rx_addr_filter #(
   parameter int DA_BYTES           = 6,
   parameter int HASH_BITS          = 6,
   parameter int MIN_LEN            = 64,
   parameter bit BCAST_OVER_PROMISC = 1'b1,
   localparam int DA_W              = 8 * DA_BYTES,
   localparam int HASH_W            = 1 << HASH_BITS,
   localparam int CNT_W             = $clog2(MIN_LEN + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_valid,
   input  logic              rx_sof,
   input  logic              rx_eof,
   input  logic [7:0]        rx_data,
   input  logic [DA_W-1:0]   cfg_station_addr,
   input  logic [HASH_W-1:0] cfg_uni_hash,
   input  logic [HASH_W-1:0] cfg_grp_hash,
   input  logic              cfg_bcast_reject,
   input  logic              cfg_promisc,
   output logic              addr_done,
   output logic              addr_accept,
   output logic              frame_done,
   output logic              frame_discard
);

   if (DA_BYTES < 1 || MIN_LEN <= DA_BYTES) begin : g_bad_len
      $error("eth_rx_addr_filter: MIN_LEN must exceed DA_BYTES >= 1");
   end
   if (HASH_BITS < 1 || HASH_BITS > 16) begin : g_bad_hash
      $error("eth_rx_addr_filter: HASH_BITS out of range");
   end

   logic                 sof_take, da_we, da_last, eof_take, runt;
   logic [CNT_W-1:0]     da_idx;
   logic [DA_W-1:0]      da;
   logic [HASH_BITS-1:0] hash_idx;
   logic                 match_ok, verdict_now;

   logic [DA_W-1:0]      station_q;
   logic [HASH_W-1:0]    uni_q, grp_q;
   logic                 bcrej_q, promisc_q;
   logic                 addr_done_q, verdict_q, fdone_q, fdisc_q;

   rxf_frame_track #(.DA_BYTES(DA_BYTES), .MIN_LEN(MIN_LEN)) trk_i (
      .clk, .rst_n, .rx_valid, .rx_sof, .rx_eof,
      .sof_take, .da_we, .da_idx, .da_last, .eof_take, .runt
   );

   rxf_da_hash #(.DA_BYTES(DA_BYTES), .HASH_BITS(HASH_BITS), .CNT_W(CNT_W)) hash_i (
      .clk, .rst_n, .sof_take, .da_we, .da_idx, .rx_data, .da, .hash_idx
   );

   rxf_match #(.DA_BYTES(DA_BYTES), .HASH_BITS(HASH_BITS),
               .BCAST_OVER_PROMISC(BCAST_OVER_PROMISC)) match_i (
      .da, .hash_idx, .station(station_q), .uni_hash(uni_q), .grp_hash(grp_q),
      .bcast_reject(bcrej_q), .promisc(promisc_q), .accept(match_ok)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         station_q <= '0;
         uni_q     <= '0;
         grp_q     <= '0;
         bcrej_q   <= 1'b0;
         promisc_q <= 1'b0;
      end else if (sof_take) begin
         station_q <= cfg_station_addr;
         uni_q     <= cfg_uni_hash;
         grp_q     <= cfg_grp_hash;
         bcrej_q   <= cfg_bcast_reject;
         promisc_q <= cfg_promisc;
      end
   end

   assign verdict_now = addr_done_q ? match_ok : verdict_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_done_q <= 1'b0;
         verdict_q   <= 1'b0;
         fdone_q     <= 1'b0;
         fdisc_q     <= 1'b0;
      end else begin
         addr_done_q <= da_last;
         if (addr_done_q) verdict_q <= match_ok;
         fdone_q     <= eof_take;
         fdisc_q     <= eof_take & (runt | ~verdict_now);
      end
   end

   assign addr_done     = addr_done_q;
   assign addr_accept   = addr_done_q & match_ok;
   assign frame_done    = fdone_q;
   assign frame_discard = fdisc_q;

endmodule

// File: rtl/rxf_addr_filter_chk.sv
module rxf_addr_filter_chk #(
   parameter int DA_BYTES = 6,
   parameter int MIN_LEN  = 64,
   localparam int CNT_W   = $clog2(MIN_LEN + 1)
) (
   input logic clk,
   input logic rst_n,
   input logic rx_valid,
   input logic rx_sof,
   input logic rx_eof,
   input logic cfg_bcast_reject,
   input logic cfg_promisc,
   input logic addr_done,
   input logic addr_accept,
   input logic frame_done,
   input logic frame_discard
);

   logic             open_q, vlatch_q, prom_s, rej_s;
   logic [CNT_W-1:0] cnt_q, last_len_q, pos, nxt;
   logic             take;

   assign take = rx_valid & (rx_sof | open_q);
   assign pos  = rx_sof ? '0 : cnt_q;
   assign nxt  = (pos == CNT_W'(MIN_LEN)) ? pos : pos + 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         open_q <= 1'b0; cnt_q <= '0; last_len_q <= '0;
         vlatch_q <= 1'b0; prom_s <= 1'b0; rej_s <= 1'b0;
      end else begin
         if (take) begin
            open_q <= ~rx_eof;
            cnt_q  <= nxt;
            if (rx_eof) last_len_q <= nxt;
         end
         if (take && rx_sof) begin
            prom_s   <= cfg_promisc;
            rej_s    <= cfg_bcast_reject;
            vlatch_q <= 1'b0;
         end else if (addr_done) begin
            vlatch_q <= addr_accept;
         end
      end
   end

   AST_ADDR_AFTER_SIXTH: assert property (@(posedge clk) disable iff (!rst_n)
      take && pos == CNT_W'(DA_BYTES - 1) |=> addr_done);                      // R7
   AST_ADDR_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      addr_done |-> $past(take && pos == CNT_W'(DA_BYTES - 1)));              // R7
   AST_ACCEPT_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      !addr_done |-> !addr_accept);                                           // R7
   AST_DONE_AFTER_EOF: assert property (@(posedge clk) disable iff (!rst_n)
      take && rx_eof |=> frame_done);                                         // R8
   AST_KEEP_NEEDS_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
      frame_done && !frame_discard |-> vlatch_q);                             // R8
   AST_RUNT_FLUSHED: assert property (@(posedge clk) disable iff (!rst_n)
      frame_done && last_len_q < CNT_W'(MIN_LEN) |-> frame_discard);         // R9
   AST_PROMISC_ACCEPTS: assert property (@(posedge clk) disable iff (!rst_n)
      addr_done && prom_s && !rej_s |-> addr_accept);                         // R6

endmodule

bind eth_rx_addr_filter rxf_addr_filter_chk #(.DA_BYTES(DA_BYTES), .MIN_LEN(MIN_LEN)) chk_i (
   .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_sof(rx_sof), .rx_eof(rx_eof),
   .cfg_bcast_reject(cfg_bcast_reject), .cfg_promisc(cfg_promisc),
   .addr_done(addr_done), .addr_accept(addr_accept),
   .frame_done(frame_done), .frame_discard(frame_discard)
);

// File: tb/eth_rx_addr_filter_tb_top.sv
module eth_rx_addr_filter_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        rx_valid = 1'b0, rx_sof = 1'b0, rx_eof = 1'b0;
   logic [7:0]  rx_data = '0;
   logic [47:0] cfg_station = '0;
   logic [63:0] cfg_uni = '0, cfg_grp = '0;
   logic        cfg_rej = 1'b0, cfg_prom = 1'b0;
   logic        addr_done, addr_accept, frame_done, frame_discard;

   int total = 0, bad = 0;
   int bytes_sent = 0;
   int got_addr = 0, addr_at = 0, got_done = 0, done_at = 0;
   logic addr_acc = 1'b0, got_disc = 1'b0;
   bit finished = 0;

   always #10 clk = ~clk;

   eth_rx_addr_filter dut_i (
      .clk, .rst_n, .rx_valid, .rx_sof, .rx_eof, .rx_data,
      .cfg_station_addr(cfg_station), .cfg_uni_hash(cfg_uni), .cfg_grp_hash(cfg_grp),
      .cfg_bcast_reject(cfg_rej), .cfg_promisc(cfg_prom),
      .addr_done, .addr_accept, .frame_done, .frame_discard
   );

   always @(posedge clk) begin
      #5;
      if (addr_done) begin got_addr++; addr_at = bytes_sent; addr_acc = addr_accept; end
      if (frame_done) begin got_done++; done_at = bytes_sent; got_disc = frame_discard; end
   end

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   function automatic logic [5:0] hidx(input logic [47:0] da);
      logic [31:0] r = 32'hFFFF_FFFF;
      for (int i = 0; i < 48; i++) begin
         if (r[31] ^ da[i]) r = {r[30:0], 1'b0} ^ 32'h04C11DB7;
         else               r = {r[30:0], 1'b0};
      end
      return r[31:26];
   endfunction

   function automatic bit exp_accept(input logic [47:0] da);
      if (&da) return !cfg_rej;
      if (cfg_prom) return 1'b1;
      if (da[0]) return cfg_grp[hidx(da)];
      return (da == cfg_station) || cfg_uni[hidx(da)];
   endfunction

   task automatic clear_mon();
      got_addr = 0; got_done = 0; addr_at = 0; done_at = 0; bytes_sent = 0;
   endtask

   task automatic send_frame(input logic [47:0] da, input int len, input int gap,
                             input bit mid_change, input string req);
      bit exp_a;
      logic [47:0] s_st; logic [63:0] s_u, s_g; logic s_r, s_p;
      exp_a = exp_accept(da);
      s_st = cfg_station; s_u = cfg_uni; s_g = cfg_grp; s_r = cfg_rej; s_p = cfg_prom;
      @(negedge clk);
      clear_mon();
      for (int i = 0; i < len; i++) begin
         while (i > 0 && ($urandom % 100) < gap) begin
            rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0; rx_data = 8'($urandom);
            @(negedge clk);
         end
         rx_valid = 1'b1; rx_sof = (i == 0); rx_eof = (i == len - 1);
         rx_data = (i < 6) ? da[8*i +: 8] : 8'($urandom);
         bytes_sent = i + 1;
         if (mid_change && i == 2) begin
            cfg_station = ~cfg_station; cfg_uni = ~cfg_uni; cfg_grp = ~cfg_grp;
            cfg_rej = ~cfg_rej; cfg_prom = ~cfg_prom;
         end
         @(negedge clk);
      end
      rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0;
      @(negedge clk);
      @(negedge clk);
      check(got_done == 1 && done_at == len, "R8", "frame_done after eof byte", done_at, len);
      if (len >= 6) begin
         check(got_addr == 1 && addr_at == 6, "R7", "addr_done after sixth byte", addr_at, 6);
         check(addr_acc == exp_a, mid_change ? "R10" : req, "address verdict", addr_acc, exp_a);
      end else begin
         check(got_addr == 0, "R9", "no addr_done for short frame", got_addr, 0);
      end
      check(got_disc == (len < 64 || !exp_a), (len < 64) ? "R9" : "R8", "discard",
            got_disc, (len < 64 || !exp_a));
      cfg_station = s_st; cfg_uni = s_u; cfg_grp = s_g; cfg_rej = s_r; cfg_prom = s_p;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         bad++; total++;
         $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [47:0] da;
      void'($urandom(32'd1234));
      repeat (3) @(negedge clk);
      check(!addr_done && !addr_accept && !frame_done && !frame_discard, "R1",
            "outputs in reset", {addr_done, addr_accept, frame_done, frame_discard}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(!addr_done && !frame_done, "R1", "outputs after reset", {addr_done, frame_done}, 0);

      cfg_station = 48'h5544_3322_1100;
      // R2: broadcast accepted/rejected by control alone, even in promiscuous mode
      cfg_uni = '1; cfg_grp = '1;
      send_frame('1, 64, 0, 0, "R2");
      cfg_rej = 1'b1; cfg_prom = 1'b1;
      send_frame('1, 70, 0, 0, "R2");
      cfg_rej = 1'b0; cfg_prom = 1'b0; cfg_uni = '0; cfg_grp = '0;
      // R3: exact station match with empty tables
      send_frame(cfg_station, 64, 0, 0, "R3");
      send_frame(cfg_station ^ 48'h0100, 64, 0, 0, "R3");
      // R4: individual hash hit on exactly the computed bit
      da = 48'hA1B2_C3D4_E5F6 & ~48'h1;
      cfg_uni = 64'h1 << hidx(da);
      send_frame(da, 64, 10, 0, "R4");
      cfg_uni = ~(64'h1 << hidx(da));
      send_frame(da, 64, 10, 0, "R4");
      cfg_uni = '0;
      // R5: group destination ignores station match, follows group table
      cfg_station = 48'h0000_0000_5E01; da = cfg_station;
      cfg_grp = ~(64'h1 << hidx(da));
      send_frame(da, 64, 0, 0, "R5");
      cfg_grp = 64'h1 << hidx(da);
      send_frame(da, 64, 0, 0, "R5");
      cfg_grp = '0; cfg_station = 48'h5544_3322_1100;
      // R6: promiscuous accepts unknown addresses
      cfg_prom = 1'b1;
      send_frame(48'h1234_5678_9A02, 64, 0, 0, "R6");
      send_frame(48'h1234_5678_9A03, 64, 0, 0, "R6");
      cfg_prom = 1'b0;
      // R9: runt boundaries
      send_frame(cfg_station, 5, 0, 0, "R9");
      send_frame(cfg_station, 6, 0, 0, "R9");
      send_frame(cfg_station, 63, 20, 0, "R9");
      send_frame(cfg_station, 64, 20, 0, "R9");
      send_frame(cfg_station, 1, 0, 0, "R9");
      // R10: config flips after capture
      cfg_prom = 1'b1;
      send_frame(48'h0BAD_F00D_0002, 64, 0, 1, "R10");
      cfg_prom = 1'b0;
      send_frame(cfg_station, 64, 0, 1, "R10");
      // R11: stray bytes between frames change nothing
      @(negedge clk);
      clear_mon();
      for (int i = 0; i < 8; i++) begin
         rx_valid = 1'b1; rx_sof = 1'b0; rx_eof = (i % 2 == 0); rx_data = 8'($urandom);
         @(negedge clk);
      end
      rx_valid = 1'b0; rx_eof = 1'b0;
      repeat (3) @(negedge clk);
      check(got_done == 0 && got_addr == 0, "R11", "stray bytes ignored", got_done + got_addr, 0);

      // random mix, with R11 gaps
      for (int n = 0; n < 80; n++) begin
         int kind, len;
         cfg_uni = {$urandom, $urandom}; cfg_grp = {$urandom, $urandom};
         cfg_rej = ($urandom % 2); cfg_prom = ($urandom % 5 == 0);
         kind = $urandom % 4;
         case (kind)
            0: da = '1;
            1: da = cfg_station;
            2: da = {$urandom, 16'($urandom)} & ~48'h1;
            default: da = {$urandom, 16'($urandom)} | 48'h1;
         endcase
         len = ($urandom % 4 == 0) ? 1 + ($urandom % 70) : 60 + ($urandom % 20);
         send_frame(da, len, $urandom % 30, ($urandom % 6 == 0),
                    kind == 0 ? "R2" : kind == 1 ? "R3" : kind == 2 ? "R4" : "R5");
      end

      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule